// File: doc/BRIEF.md
# Lockable Peripheral Clock-Channel Control Bank

This block holds one control word per peripheral clock channel. Each word names which of eight clock generators feeds the channel and whether the channel is switched on. Software reaches the words over a simple register bus with byte enables. Each word also carries a sticky lock bit. Once the lock bit is set, the word is frozen. The lock is also passed on to the generator the word selects, through an 8-bit lock vector. A separate generator-control bank uses that vector to refuse writes. Generator 0 is never locked through this vector.

There are two resets. Power reset is asynchronous and active low, and it clears everything, including the locks. User reset is a synchronous pulse. It clears only the channels that are not locked and never touches a lock bit.

The channel enable crosses into the channel's own clock domain through a request/acknowledge handshake. The enable bit read back over the bus is the acknowledged value. A per-channel busy flag shows that a change is still travelling. If the enable is rewritten while a transfer is in flight, the newest value is held and sent once the current transfer ends. No error is raised.

Top module: `clkchan_bank`

## Requirements
- R1: After power reset, every channel word reads 0x00000000, the generator lock vector is 0 and no busy flag is set.
- R2: A write with byte enable 0 set to word-aligned address 0x080 + 4*m (m from 0 to 34) stores bits 2:0 as the generator select, bit 6 as the enable and bit 7 as the lock. A read of that address returns the select in bits 2:0 and the lock in bit 7 from the cycle after the write. Bits 31:8 and 5:3 always read 0.
- R3: While a channel's lock bit is 1, writes to that channel change nothing. The lock bit stays 1 until power reset.
- R4: Bit g (g from 1 to 7) of the generator lock vector is 1 exactly when some locked channel selects generator g. The vector reflects a lock write in the cycle after it.
- R5: Bit 0 of the generator lock vector is always 0, even when a locked channel selects generator 0.
- R6: A user reset pulse clears the select and enable of every unlocked channel. It leaves locked channels and all lock bits unchanged. A bus write in the same cycle as a user reset is discarded.
- R7: Power reset asserted in the middle of operation clears every field of every channel, locks included.
- R8: After an enable change, the channel's busy flag goes high and stays high until the channel-domain enable output has taken the new value. Bit 6 read back shows the acknowledged enable, so it equals the written value once busy is low.
- R9: If the enable is rewritten while the channel is busy, the last value written is the one that finally reaches the channel-domain output and bit 6.
- R10: Reads of any address that is not one of the 35 word-aligned channel addresses return 0. Writes there have no effect. A write to a channel address with byte enable 0 clear has no effect.
- R11: The select output for channel m (bits 3m+2:3m) always equals that channel's stored generator select.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Register bus clock |
| rst_por_n | input | 1 | Power reset, asynchronous, active low |
| user_rst | input | 1 | User reset pulse, synchronous, active high |
| wr_en | input | 1 | Write strobe |
| addr | input | 12 | Byte address |
| wdata | input | 32 | Write data |
| be | input | 4 | Byte enables for the write |
| rdata | output | 32 | Read data for addr, combinational |
| chan_clk | input | 35 | One clock per channel domain |
| chan_en_o | output | 35 | Channel enables in each channel domain |
| chan_busy_o | output | 35 | Enable transfer in progress per channel |
| chan_sel_o | output | 105 | Generator select per channel, 3 bits each |
| gen_lock_o | output | 8 | Lock request per generator |

## Verification
Two pairs of events can land in the same cycle. One pair is a bus write and a user reset pulse. The bench drives both in one cycle, aimed at an unlocked channel with a lock-setting value. It then reads back that the write was discarded and that the locked channels and the lock vector are unchanged. The other pair is an enable rewrite and an enable transfer still in flight. The bench writes opposite enable values on back-to-back cycles and, once busy drops, checks that only the last value reached the channel-domain output. Random traffic mixes writes, sparse locks, byte-enable gaps, stray addresses and user resets. After each burst it compares every word against a bench model.

// File: rtl/clkchan_pkg.sv
package clkchan_pkg;
  localparam int DATA_W   = 32;
  localparam int GEN_N    = 8;
  localparam int GEN_SELW = $clog2(GEN_N);
  localparam int EN_BIT   = 6;
  localparam int LOCK_BIT = 7;
  typedef logic [GEN_SELW-1:0] gen_sel_t;
endpackage

// File: rtl/chan_reg.sv
module chan_reg
  import clkchan_pkg::*;
(
  input  logic     clk,
  input  logic     rst_por_n,
  input  logic     user_rst,
  input  logic     wr_hit,
  input  logic [7:0] wbyte,
  output gen_sel_t sel_q,
  output logic     want_q,
  output logic     lock_q
);
  gen_sel_t sel_d;
  logic     want_d, lock_d, ld;
  logic     unused_bits;

  assign unused_bits = ^wbyte[5:GEN_SELW];

  always_comb begin
    sel_d  = sel_q;
    want_d = want_q;
    lock_d = lock_q;
    ld     = 1'b0;
    if (user_rst) begin
      if (!lock_q) begin
        sel_d  = '0;
        want_d = 1'b0;
        ld     = 1'b1;
      end
    end else if (wr_hit && !lock_q) begin
      sel_d  = wbyte[GEN_SELW-1:0];
      want_d = wbyte[EN_BIT];
      lock_d = wbyte[LOCK_BIT];
      ld     = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_por_n) begin
    if (!rst_por_n) begin
      sel_q  <= '0;
      want_q <= 1'b0;
      lock_q <= 1'b0;
    end else if (ld) begin
      sel_q  <= sel_d;
      want_q <= want_d;
      lock_q <= lock_d;
    end
  end
endmodule

// File: rtl/en_handshake.sv
module en_handshake #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_por_n,
  input  logic far_clk,
  input  logic want,
  output logic ack,
  output logic busy,
  output logic far_en
);
  logic                   req_q, req_d, req_ld;
  logic [SYNC_STAGES-1:0] fwd_q, bck_q;

  always_comb begin
    req_ld = (req_q == ack) && (want != req_q);
    req_d  = want;
  end

  always_ff @(posedge clk or negedge rst_por_n) begin
    if (!rst_por_n) req_q <= 1'b0;
    else if (req_ld) req_q <= req_d;
  end

  always_ff @(posedge far_clk or negedge rst_por_n) begin
    if (!rst_por_n) fwd_q <= '0;
    else fwd_q <= {fwd_q[SYNC_STAGES-2:0], req_q};
  end

  assign far_en = fwd_q[SYNC_STAGES-1];

  always_ff @(posedge clk or negedge rst_por_n) begin
    if (!rst_por_n) bck_q <= '0;
    else bck_q <= {bck_q[SYNC_STAGES-2:0], far_en};
  end

  assign ack  = bck_q[SYNC_STAGES-1];
  assign busy = (req_q != ack) || (want != ack);
endmodule

// File: rtl/gen_lock_or.sv
module gen_lock_or
  import clkchan_pkg::*;
#(
  parameter int NCH = 35
) (
  input  logic [NCH-1:0]          lock_q,
  input  logic [NCH*GEN_SELW-1:0] sel_flat,
  output logic [GEN_N-1:0]        gen_lock
);
  always_comb begin
    gen_lock = '0;
    for (int m = 0; m < NCH; m++) begin
      if (lock_q[m]) gen_lock[sel_flat[m*GEN_SELW +: GEN_SELW]] = 1'b1;
    end
    gen_lock[0] = 1'b0;
  end
endmodule

// File: rtl/clkchan_bank.sv
module clkchan_bank
  import clkchan_pkg::*;
#(
  parameter int          NCH     = 35,
  parameter int          ADDR_W  = 12,
  parameter logic [11:0] CH_BASE = 12'h080
) (
  input  logic                    clk,
  input  logic                    rst_por_n,
  input  logic                    user_rst,
  input  logic                    wr_en,
  input  logic [ADDR_W-1:0]       addr,
  input  logic [DATA_W-1:0]       wdata,
  input  logic [3:0]              be,
  output logic [DATA_W-1:0]       rdata,
  input  logic [NCH-1:0]          chan_clk,
  output logic [NCH-1:0]          chan_en_o,
  output logic [NCH-1:0]          chan_busy_o,
  output logic [NCH*GEN_SELW-1:0] chan_sel_o,
  output logic [GEN_N-1:0]        gen_lock_o
);
  logic [NCH-1:0]          addr_match, wr_hit, lock_q, want_q, ack_q;
  logic [NCH*GEN_SELW-1:0] sel_flat;
  logic                    any_hit;
  logic                    unused_in;

  assign unused_in = ^{wdata[DATA_W-1:8], be[3:1]};

  for (genvar m = 0; m < NCH; m++) begin : g_ch
    localparam logic [ADDR_W-1:0] CH_ADDR = ADDR_W'(CH_BASE + 4*m);
    gen_sel_t sel_m;

    assign addr_match[m] = (addr == CH_ADDR);
    assign wr_hit[m]     = wr_en && be[0] && addr_match[m];

    chan_reg u_reg (
      .clk       (clk),
      .rst_por_n (rst_por_n),
      .user_rst  (user_rst),
      .wr_hit    (wr_hit[m]),
      .wbyte     (wdata[7:0]),
      .sel_q     (sel_m),
      .want_q    (want_q[m]),
      .lock_q    (lock_q[m])
    );

    assign sel_flat[m*GEN_SELW +: GEN_SELW] = sel_m;

    en_handshake #(.SYNC_STAGES(2)) u_hs (
      .clk       (clk),
      .rst_por_n (rst_por_n),
      .far_clk   (chan_clk[m]),
      .want      (want_q[m]),
      .ack       (ack_q[m]),
      .busy      (chan_busy_o[m]),
      .far_en    (chan_en_o[m])
    );
  end

  assign any_hit    = |addr_match;
  assign chan_sel_o = sel_flat;

  always_comb begin
    rdata = '0;
    for (int m = 0; m < NCH; m++) begin
      if (addr_match[m]) begin
        rdata[GEN_SELW-1:0] = sel_flat[m*GEN_SELW +: GEN_SELW];
        rdata[EN_BIT]       = ack_q[m];
        rdata[LOCK_BIT]     = lock_q[m];
      end
    end
  end

  gen_lock_or #(.NCH(NCH)) u_glk (
    .lock_q   (lock_q),
    .sel_flat (sel_flat),
    .gen_lock (gen_lock_o)
  );
endmodule

// File: rtl/clkchan_bank_chk.sv
module clkchan_bank_chk
  import clkchan_pkg::*;
#(
  parameter int NCH = 35
) (
  input logic                    clk,
  input logic                    rst_por_n,
  input logic                    user_rst,
  input logic                    wr_en,
  input logic                    any_hit,
  input logic [NCH-1:0]          lock_q,
  input logic [NCH-1:0]          want_q,
  input logic [NCH-1:0]          ack_q,
  input logic [NCH-1:0]          chan_busy_o,
  input logic [NCH*GEN_SELW-1:0] sel_flat,
  input logic [GEN_N-1:0]        gen_lock_o
);
  for (genvar m = 0; m < NCH; m++) begin : g_a
    a_r3_lock_sticky: assert property (@(posedge clk) disable iff (!rst_por_n)
      lock_q[m] |=> lock_q[m] && $stable(sel_flat[m*GEN_SELW +: GEN_SELW]) && $stable(want_q[m]));
    a_r4_gen_lock_set: assert property (@(posedge clk) disable iff (!rst_por_n)
      (lock_q[m] && sel_flat[m*GEN_SELW +: GEN_SELW] != '0)
        |-> gen_lock_o[sel_flat[m*GEN_SELW +: GEN_SELW]]);
    a_r6_user_clear: assert property (@(posedge clk) disable iff (!rst_por_n)
      (user_rst && !lock_q[m]) |=> (sel_flat[m*GEN_SELW +: GEN_SELW] == '0) && !want_q[m] && !lock_q[m]);
    a_r8_ack_moves_busy: assert property (@(posedge clk) disable iff (!rst_por_n)
      !$stable(ack_q[m]) |-> $past(chan_busy_o[m]));
  end

  a_r10_stray_write: assert property (@(posedge clk) disable iff (!rst_por_n)
    (wr_en && !any_hit && !user_rst) |=> $stable(sel_flat) && $stable(lock_q) && $stable(want_q));
endmodule

bind clkchan_bank clkchan_bank_chk #(.NCH(NCH)) u_chk (
  .clk         (clk),
  .rst_por_n   (rst_por_n),
  .user_rst    (user_rst),
  .wr_en       (wr_en),
  .any_hit     (any_hit),
  .lock_q      (lock_q),
  .want_q      (want_q),
  .ack_q       (ack_q),
  .chan_busy_o (chan_busy_o),
  .sel_flat    (sel_flat),
  .gen_lock_o  (gen_lock_o)
);

// File: tb/clkchan_bank_tb.sv
module clkchan_bank_tb;
  localparam int NCH = 35;

  logic clk = 1'b0, fclk = 1'b0;
  logic rst_por_n, user_rst, wr_en;
  logic [11:0] addr;
  logic [31:0] wdata, rdata;
  logic [3:0]  be;
  logic [NCH-1:0] chan_en_o, chan_busy_o;
  logic [NCH*3-1:0] chan_sel_o;
  logic [7:0] gen_lock_o;

  always #2 clk = ~clk;
  always #3.5 fclk = ~fclk;

  clkchan_bank u_dut (
    .clk(clk), .rst_por_n(rst_por_n), .user_rst(user_rst), .wr_en(wr_en),
    .addr(addr), .wdata(wdata), .be(be), .rdata(rdata),
    .chan_clk({NCH{fclk}}), .chan_en_o(chan_en_o), .chan_busy_o(chan_busy_o),
    .chan_sel_o(chan_sel_o), .gen_lock_o(gen_lock_o)
  );

  int tests = 0, fails = 0;
  logic [2:0] m_sel [NCH];
  logic       m_en  [NCH];
  logic       m_lock[NCH];

  task automatic chk(input string rq, input logic [127:0] act, input logic [127:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  function automatic logic [11:0] ch_addr(input int m);
    return 12'(12'h080 + 4*m);
  endfunction

  function automatic logic [31:0] exp_word(input int m);
    return {24'b0, m_lock[m], m_en[m], 3'b0, m_sel[m]};
  endfunction

  function automatic logic [7:0] exp_glock();
    logic [7:0] v = '0;
    for (int m = 0; m < NCH; m++) if (m_lock[m]) v[m_sel[m]] = 1'b1;
    v[0] = 1'b0;
    return v;
  endfunction

  function automatic logic [NCH*3-1:0] exp_sel();
    logic [NCH*3-1:0] v;
    for (int m = 0; m < NCH; m++) v[m*3 +: 3] = m_sel[m];
    return v;
  endfunction

  task automatic model_clear_all();
    for (int m = 0; m < NCH; m++) begin m_sel[m] = 0; m_en[m] = 0; m_lock[m] = 0; end
  endtask

  task automatic model_write(input logic [11:0] a, input logic [31:0] d, input logic [3:0] b);
    for (int m = 0; m < NCH; m++)
      if (a == ch_addr(m) && b[0] && !m_lock[m]) begin
        m_sel[m] = d[2:0]; m_en[m] = d[6]; m_lock[m] = d[7];
      end
  endtask

  task automatic model_user_rst();
    for (int m = 0; m < NCH; m++) if (!m_lock[m]) begin m_sel[m] = 0; m_en[m] = 0; end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d, input logic [3:0] b);
    @(negedge clk);
    addr = a; wdata = d; be = b; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
    model_write(a, d, b);
  endtask

  task automatic wr_with_urst(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    addr = a; wdata = d; be = 4'hF; wr_en = 1'b1; user_rst = 1'b1;
    @(negedge clk);
    wr_en = 1'b0; user_rst = 1'b0;
    model_user_rst();
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    addr = a; wr_en = 1'b0;
    #1 d = rdata;
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 200; i++) begin
      @(negedge clk);
      if (chan_busy_o == '0) break;
    end
  endtask

  task automatic por();
    @(negedge clk);
    rst_por_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_por_n = 1'b1;
    model_clear_all();
  endtask

  task automatic check_all(input string rq);
    logic [31:0] d;
    wait_idle();
    for (int m = 0; m < NCH; m++) begin
      rd(ch_addr(m), d);
      chk(rq, d, exp_word(m));
      chk({rq, " en_o"}, chan_en_o[m], m_en[m]);
    end
    chk({rq, " glock"}, gen_lock_o, exp_glock());
    chk("R11 sel out", chan_sel_o, exp_sel());
    chk({rq, " idle"}, chan_busy_o, '0);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    fails++; tests++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin : stim
    logic [31:0] d;
    logic seen_busy;
    rst_por_n = 1'b0; user_rst = 1'b0; wr_en = 1'b0;
    addr = '0; wdata = '0; be = '0;
    model_clear_all();
    repeat (4) @(negedge clk);
    rst_por_n = 1'b1;

    // R1: reset state
    check_all("R1 reset");

    // R2 / R8: field layout, enable readback after handshake
    wr(ch_addr(3), 32'hABCD_007D, 4'hF);
    #1;
    chk("R8 busy after write", chan_busy_o[3], 1'b1);
    rd(ch_addr(3), d);
    chk("R2 sel next cycle", d[2:0], 3'd5);
    chk("R8 en not yet acked", d[6], 1'b0);
    wait_idle();
    rd(ch_addr(3), d);
    chk("R2 layout", d, 32'h0000_0045);
    chk("R8 en_o", chan_en_o[3], 1'b1);
    chk("R11 sel out", chan_sel_o[3*3 +: 3], 3'd5);

    // R9: rewrite while busy
    wr(ch_addr(4), 32'h40, 4'h1);
    seen_busy = chan_busy_o[4];
    wr(ch_addr(4), 32'h00, 4'h1);
    chk("R9 busy during rewrite", seen_busy, 1'b1);
    wait_idle();
    rd(ch_addr(4), d);
    chk("R9 last value wins", d, 32'h0);
    chk("R9 en_o", chan_en_o[4], 1'b0);

    // R10: stray addresses and byte enables
    wr(ch_addr(NCH), 32'hFF, 4'hF);
    rd(ch_addr(NCH), d);
    chk("R10 beyond range", d, 32'h0);
    wr(12'h082, 32'hC3, 4'hF);
    rd(12'h082, d);
    chk("R10 unaligned read", d, 32'h0);
    wr(ch_addr(5), 32'h47, 4'b1110);
    rd(ch_addr(5), d);
    chk("R10 be0 clear", d, 32'h0);
    check_all("R10 no effect");

    // R4 / R3 / R5
    wr(ch_addr(7), 32'h83, 4'h1);
    #1;
    chk("R4 lock vector next cycle", gen_lock_o, 8'h08);
    wr(ch_addr(7), 32'h05, 4'h1);
    rd(ch_addr(7), d);
    chk("R3 locked ignores write", d, 32'h83);
    wr(ch_addr(8), 32'h80, 4'h1);
    #1;
    chk("R5 gen0 never locked", gen_lock_o, 8'h08);

    // R6: user reset with same-cycle write
    wr_with_urst(ch_addr(9), 32'h86);
    check_all("R6 user reset");
    rd(ch_addr(9), d);
    chk("R6 write discarded", d, 32'h0);

    // R7: power reset clears locks
    por();
    check_all("R7 power reset");

    // Random traffic
    void'($urandom(32'h1F2E3D4C));
    for (int it = 0; it < 40; it++) begin
      for (int k = 0; k < 12; k++) begin
        int pick = int'($urandom % 20);
        logic [31:0] rd_d = $urandom;
        rd_d[7] = (($urandom % 12) == 0);
        if (pick < 15)
          wr(ch_addr(int'($urandom % NCH)), rd_d, 4'($urandom));
        else if (pick < 18)
          wr(12'($urandom % 12'h200), rd_d, 4'hF);
        else if (pick < 19)
          wr_with_urst(ch_addr(int'($urandom % NCH)), rd_d);
        else begin
          @(negedge clk); user_rst = 1'b1;
          @(negedge clk); user_rst = 1'b0;
          model_user_rst();
        end
      end
      check_all("R2 R3 R4 R6 R10 random");
      if (it % 10 == 9) begin
        por();
        check_all("R7 random power reset");
      end
    end

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule